// File: doc/BRIEF.md
# Converter Sequencing Control Register

This block holds one 8-bit control and status register and the state machine that runs an external analog-to-digital converter core. Software reaches the register over a simple select/write bus. A conversion starts when the start bit is written to 1 or when a rising edge arrives on the trigger input. The block then issues a one-cycle start request with a channel number and waits for the converter's done pulse.

In single mode one channel is converted. The start bit then clears itself and the end flag sets. In scan mode the channels run from 0 up to the selected channel and then wrap back to 0. This repeats until software writes 0 to the start bit or standby is asserted, and the end flag sets each time a full pass completes. The interrupt output is the end flag gated by the enable bit. Software can clear the end flag only by writing 0 after a read that returned it as 1. A DMA acknowledge also clears it.

The sequencer has three states. `SEQ_IDLE` goes to `SEQ_ISSUE` when the start bit is set. `SEQ_ISSUE` drives the start request for one cycle and goes to `SEQ_WAIT`. `SEQ_WAIT` waits for done. After a done in single mode it returns to `SEQ_IDLE`. After a done in scan mode it returns to `SEQ_ISSUE` with the next channel. A stop (a write of 0 to start, or standby) sends `SEQ_ISSUE` or `SEQ_WAIT` straight to `SEQ_IDLE`, and a done that arrives in that cycle is dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, or in any cycle where standby was asserted, the register reads 0x00 and no start request is issued. Standby also aborts a running scan.
- R2: The register bits are: bit 7 end flag, bit 6 interrupt enable, bit 5 start, bit 4 scan mode, bit 3 clock select, bits 2:0 channel. Bits 6, 4, 3 and 2:0 read back as written, and bit 3 drives `clk_sel`.
- R3: In single mode (bit 4 = 0), setting bit 5 issues exactly one `conv_start` pulse, one cycle long, with `conv_chan` equal to bits 2:0. On `conv_done` the end flag sets and bit 5 clears.
- R4: In scan mode (bit 4 = 1), the start requests use channels 0, 1, …, N in ascending order, where N is bits 2:0, and then wrap to 0. Bit 5 stays 1 until it is cleared.
- R5: In scan mode the end flag sets only when channel N completes, and not when the lower channels complete.
- R6: A write with bit 7 = 0 clears the end flag only if a read has returned the flag as 1 since it was last clear. Without such a read the flag stays 1. Writing 1 to bit 7 has no effect.
- R7: A one-cycle `dma_ack` pulse clears the end flag.
- R8: `irq` is 1 exactly when the end flag and bit 6 are both 1.
- R9: A rising edge on `trig` sets bit 5. Holding `trig` high does not start a second conversion.
- R10: Writing 0 to bit 5 while a conversion is in flight stops the sequence. The done pulse of that conversion does not set the flag, and no further start request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of register and sequencer |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read when selected |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| trig | input | 1 | External start trigger, rising edge active |
| dma_ack | input | 1 | DMA result read acknowledge, clears end flag |
| conv_done | input | 1 | Converter done pulse |
| conv_start | output | 1 | One-cycle start request to converter |
| conv_chan | output | 3 | Channel for the current request |
| clk_sel | output | 1 | Clock select bit to the divider |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The sequencer is exercised with a single conversion on a high channel, a three-channel scan allowed to run past two wraps, a single conversion stopped before its done pulse, a trigger held high, and a scan aborted by standby. The scoreboard records the interrupt level at each start request. This distinguishes a flag that sets at the end of a full pass from one that sets after each channel. The order of the flag writes and reads separates a write of 0 that was armed by a read from one that was not, and separates both from a write of 1.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_eoc_flag.sv
module adc_eoc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_evt,
    input  logic rd_stb,
    input  logic clr_wr,
    input  logic dma_ack,
    output logic flag
);
    logic flag_q, armed_q;
    logic clr_now;

    // a set in the same cycle outranks any clear
    assign clr_now = ~set_evt & (dma_ack | (clr_wr & armed_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (standby) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_evt)      flag_q <= 1'b1;
            else if (clr_now) flag_q <= 1'b0;
            if (clr_now)                armed_q <= 1'b0;
            else if (rd_stb && flag_q)  armed_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    // R6: the flag only ever falls through an armed write, a DMA ack or standby
    assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(dma_ack || standby || (clr_wr && armed_q)));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            halt,
    input  logic            scan,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            pass_done,
    output logic            single_end
);
    seq_state_e      st_q, st_d;
    logic [CH_W-1:0] cur_q, cur_d;
    logic            run_ok, last_ch, finish;

    assign run_ok  = go & ~halt;
    assign last_ch = (cur_q == chan_sel);
    assign finish  = (st_q == SEQ_WAIT) & run_ok & conv_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        unique case (st_q)
            SEQ_IDLE: begin
                if (run_ok) begin
                    st_d  = SEQ_ISSUE;
                    cur_d = scan ? '0 : chan_sel;
                end
            end
            SEQ_ISSUE: begin
                st_d = run_ok ? SEQ_WAIT : SEQ_IDLE;
            end
            SEQ_WAIT: begin
                if (!run_ok) begin
                    st_d = SEQ_IDLE;
                end else if (conv_done) begin
                    if (!scan) begin
                        st_d = SEQ_IDLE;
                    end else begin
                        st_d  = SEQ_ISSUE;
                        cur_d = last_ch ? '0 : cur_q + CH_W'(1);
                    end
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_start = (st_q == SEQ_ISSUE) & run_ok;
        conv_chan  = cur_q;
        pass_done  = finish & (~scan | last_ch);
        single_end = finish & ~scan;
    end

    // R3: the start request is a single-cycle pulse
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R3: a completed single conversion returns the sequencer to idle
    assert_single_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        single_end |=> st_q == SEQ_IDLE);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CH_W+4:0]   bus_wdata,
    output logic [CH_W+4:0]   bus_rdata,
    input  logic              trig,
    input  logic              dma_ack,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              clk_sel,
    output logic              irq
);
    localparam int POS_CLK  = CH_W;
    localparam int POS_SCAN = CH_W + 1;
    localparam int POS_GO   = CH_W + 2;
    localparam int POS_IE   = CH_W + 3;
    localparam int POS_FLAG = CH_W + 4;

    logic            irq_en_q, go_q, scan_q, clk_sel_q, trig_q, go_d;
    logic [CH_W-1:0] chan_q;
    logic            wr_stb, rd_stb, trig_rise, halt;
    logic            flag, pass_done, single_end;

    assign wr_stb    = bus_sel & bus_wr;
    assign rd_stb    = bus_sel & ~bus_wr;
    assign trig_rise = trig & ~trig_q;
    assign halt      = standby | (wr_stb & ~bus_wdata[POS_GO]);

    always_comb begin
        go_d = go_q;
        if (single_end) go_d = 1'b0;
        if (wr_stb)     go_d = bus_wdata[POS_GO];
        if (trig_rise)  go_d = 1'b1;
        if (standby)    go_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q  <= 1'b0;
            go_q      <= 1'b0;
            scan_q    <= 1'b0;
            clk_sel_q <= 1'b0;
            chan_q    <= '0;
            trig_q    <= 1'b0;
        end else begin
            trig_q <= trig;
            go_q   <= go_d;
            if (standby) begin
                irq_en_q  <= 1'b0;
                scan_q    <= 1'b0;
                clk_sel_q <= 1'b0;
                chan_q    <= '0;
            end else if (wr_stb) begin
                irq_en_q  <= bus_wdata[POS_IE];
                scan_q    <= bus_wdata[POS_SCAN];
                clk_sel_q <= bus_wdata[POS_CLK];
                chan_q    <= bus_wdata[CH_W-1:0];
            end
        end
    end

    adc_eoc_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .set_evt (pass_done),
        .rd_stb  (rd_stb),
        .clr_wr  (wr_stb & ~bus_wdata[POS_FLAG]),
        .dma_ack (dma_ack),
        .flag    (flag)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_q),
        .halt       (halt),
        .scan       (scan_q),
        .chan_sel   (chan_q),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .pass_done  (pass_done),
        .single_end (single_end)
    );

    assign bus_rdata = {flag, irq_en_q, go_q, scan_q, clk_sel_q, chan_q};
    assign clk_sel   = clk_sel_q;
    assign irq       = flag & irq_en_q;

    // R1: standby leaves the whole register at zero
    assert_standby_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (bus_rdata == '0) && !conv_start);
    // R5: a completed pass always shows up as a set flag
    assert_pass_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> bus_rdata[POS_FLAG]);
    // R7: a DMA acknowledge without a coincident set empties the flag
    assert_dma_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !pass_done) |=> !bus_rdata[POS_FLAG]);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       trig = 1'b0;
    logic       dma_ack = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       clk_sel;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int starts = 0;
    int busy_cnt = 0;
    int exp_q[$];
    localparam int LAT = 4;

    always #4 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig(trig), .dma_ack(dma_ack), .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan), .clk_sel(clk_sel), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // converter model and scoreboard monitor: item = chan | irq<<8
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) conv_done = 1'b1;
        end
        if (conv_start) begin
            starts++;
            busy_cnt = LAT;
            if (exp_q.size() == 0) begin
                chk("R3/R4/R10 unexpected start", int'(conv_chan), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R3/R4/R5 start chan+irq", int'(conv_chan) | (int'(irq) << 8), e);
            end
        end
    end

    task automatic push(input int ch, input int irqv);
        exp_q.push_back(ch | (irqv << 8));
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_starts(input int n);
        while (starts < n) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        bus_read(d); chk("R1 reset value", d, 8'h00);
        chk("R1 reset irq", irq, 0);

        // R2 field read-back, no start without bit 5
        bus_write(8'h5A); bus_read(d);
        chk("R2 readback", d, 8'h5A);
        chk("R2 clk_sel out", clk_sel, 1);
        bus_write(8'h00);

        // R3 single conversion on channel 5
        push(5, 0);
        bus_write(8'h25); idle(15);
        // R6 write 0 without an earlier read keeps flag; R8 irq with ie
        bus_write(8'h45); chk("R8 irq when flag and ie", irq, 1);
        bus_read(d); chk("R3/R6 flag set, start cleared", d, 8'hC5);
        bus_write(8'h85); chk("R8 irq off with ie 0", irq, 0);
        bus_read(d); chk("R6 write 1 ignored", d, 8'h85);
        bus_write(8'h05); bus_read(d); chk("R6 armed write 0 clears", d, 8'h05);

        // R7 DMA acknowledge
        push(5, 0);
        bus_write(8'h25); idle(15);
        bus_read(d); chk("R7 flag before ack", d, 8'h85);
        @(negedge clk); dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
        bus_read(d); chk("R7 ack clears flag", d, 8'h05);

        // R4/R5 scan over channels 0..2 with interrupt enabled
        push(0, 0); push(1, 0); push(2, 0);
        push(0, 1); push(1, 1); push(2, 1); push(0, 1);
        bus_write(8'h72);
        wait_starts(5);
        bus_read(d); chk("R4 start stays set in scan", int'(d[5]), 1);
        wait_starts(9);
        bus_write(8'h52); idle(20);
        bus_read(d); chk("R4 stop by software", d, 8'hD2);
        bus_write(8'h00); bus_read(d); chk("R6 clear after scan", d, 8'h00);

        // R10 stop a single conversion in flight
        push(3, 0);
        bus_write(8'h23);
        wait_starts(10);
        bus_write(8'h03); idle(15);
        bus_read(d); chk("R10 dropped done leaves flag clear", d, 8'h03);

        // R9 trigger edge, held high
        push(1, 0);
        bus_write(8'h01);
        @(negedge clk); trig = 1'b1;
        idle(25);
        bus_read(d); chk("R9 trigger single run", d, 8'h81);
        chk("R9 one start only", starts, 11);
        trig = 1'b0;
        bus_write(8'h01); bus_read(d); chk("R6 clear after trigger run", d, 8'h01);

        // R1 standby aborts a scan
        push(0, 0); push(0, 0);
        bus_write(8'h30);
        wait_starts(13);
        @(negedge clk); standby = 1'b1;
        idle(2); standby = 1'b0;
        bus_read(d); chk("R1 standby clears register", d, 8'h00);
        idle(20);
        chk("R1 no start after standby", starts, 13);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule